// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the addresses for one synchronous burst memory access. A load command captures a full address. Each later advance command steps the low address bits through a four-beat burst, and the upper bits stay as loaded. The burst runs in one of two orders. In linear order the low bits count up modulo four from the loaded value. In interleaved order the low bits are the loaded value XOR the beat index. If advancing goes on past the fourth beat, the sequence comes back to the loaded start address.

Three static controls shape the outputs. One control picks the order. A second picks flow-through timing, where the address and valid outputs follow the command after one clock edge, or pipelined timing, which adds one more register stage. A power-down request puts the block into standby: it freezes the burst state, ignores commands and suppresses beat valid. A done flag marks the fourth beat of every burst.

Top module: `burst_addr_seq`

## Requirements
- R1: In flow-through mode (pipe_i=0), a load sampled at a clock edge makes valid_o high and addr_o equal to addr_i right after that edge. With no command at the next edge, valid_o falls after that edge.
- R2: With order_i=0 (linear), the advances after a load give low bits start+1, start+2 and start+3, modulo four. Example: start 11 gives 11, 00, 01, 10.
- R3: With order_i=1 (interleaved), the low bits of beats 1 to 4 are start XOR 00, 01, 10 and 11. Example: start 01 gives 01, 00, 11, 10.
- R4: An advance after the fourth beat returns the low bits to the loaded start value.
- R5: Address bits above the two low bits keep their loaded value for the whole burst.
- R6: A load sampled together with an advance wins. The burst restarts at beat one of the new address, and the next advance gives that burst's second beat.
- R7: In pipelined mode (pipe_i=1), addr_o and valid_o for a command appear one edge later than in flow-through mode.
- R8: While sleep_i is high at an edge, load and advance at that edge are ignored and the burst state is held. standby_o follows sleep_i one edge later, and valid_o is low while standby_o is high.
- R9: done_o is high for exactly the one cycle in which the fourth beat of a burst is valid.
- R10: An advance before any load since reset is ignored, and valid_o stays low.
- R11: During reset addr_o, valid_o, done_o and standby_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_i | input | 1 | Load addr_i and start a burst |
| adv_i | input | 1 | Step to the next beat |
| addr_i | input | AW | Address to load |
| order_i | input | 1 | 0 linear order, 1 interleaved order |
| pipe_i | input | 1 | 0 flow-through, 1 pipelined output timing |
| sleep_i | input | 1 | 1 requests standby |
| addr_o | output | AW | Current beat address |
| valid_o | output | 1 | A beat address is presented |
| done_o | output | 1 | Fourth beat of the burst |
| standby_o | output | 1 | Block is in standby |

## Verification
The properties assume that order_i and pipe_i are static while a burst is in flight, and that they change only while the block is idle. For example, a burst is never split across a change of timing mode. The bench sets both controls only after two idle cycles. It drives commands one per clock edge, as single-cycle pulses, and holds ld_i low during reset. The properties that look back across edges count the cycles since reset, so they never judge input values sampled while reset was held.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   typedef enum logic {
      TIM_FLOW = 1'b0,
      TIM_PIPE = 1'b1
   } timing_e;
endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
   parameter int AW = 16,
   parameter int LB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic          adv,
   input  logic          sleep,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] base,
   output logic [LB-1:0] beat,
   output logic          fresh
);
   logic active;
   logic take_ld;
   logic take_adv;

   // standby blocks everything; load outranks advance
   assign take_ld  = ld && !sleep;
   assign take_adv = adv && !ld && !sleep && active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base   <= '0;
         beat   <= '0;
         active <= 1'b0;
         fresh  <= 1'b0;
      end else begin
         fresh <= take_ld || take_adv;
         if (take_ld) begin
            base   <= addr_in;
            beat   <= '0;
            active <= 1'b1;
         end else if (take_adv) begin
            beat <= beat + LB'(1);
         end
      end
   end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int LB = 2
) (
   input  logic [LB-1:0] start,
   input  logic [LB-1:0] beat,
   input  order_e        order,
   output logic [LB-1:0] low,
   output logic          last
);
   always_comb begin
      unique case (order)
         ORD_INTERLEAVE: low = start ^ beat;
         default:        low = start + beat;
      endcase
   end

   assign last = &beat;
endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage
   import burst_seq_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  timing_e       timing,
   input  logic          sleep,
   input  logic [AW-1:0] addr_f,
   input  logic          valid_f,
   input  logic          done_f,
   output logic [AW-1:0] addr_o,
   output logic          valid_o,
   output logic          done_o,
   output logic          standby_o
);
   logic [AW-1:0] addr_p;
   logic          valid_p;
   logic          done_p;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_p    <= '0;
         valid_p   <= 1'b0;
         done_p    <= 1'b0;
         standby_o <= 1'b0;
      end else begin
         addr_p    <= addr_f;
         valid_p   <= valid_f;
         done_p    <= done_f;
         standby_o <= sleep;
      end
   end

   always_comb begin
      if (timing == TIM_PIPE) begin
         addr_o  = addr_p;
         valid_o = valid_p && !standby_o;
         done_o  = done_p && !standby_o;
      end else begin
         addr_o  = addr_f;
         valid_o = valid_f && !standby_o;
         done_o  = done_f && !standby_o;
      end
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int AW = 16,
   parameter int LB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_i,
   input  logic          adv_i,
   input  logic [AW-1:0] addr_i,
   input  logic          order_i,
   input  logic          pipe_i,
   input  logic          sleep_i,
   output logic [AW-1:0] addr_o,
   output logic          valid_o,
   output logic          done_o,
   output logic          standby_o
);
   localparam int HI = AW - LB;

   if (LB < 1 || LB > 8) begin : g_bad_lb
      $error("burst_addr_seq: LB must lie in 1..8");
   end
   if (HI < 1) begin : g_bad_aw
      $error("burst_addr_seq: AW must exceed LB");
   end

   logic [AW-1:0] base;
   logic [LB-1:0] beat;
   logic [LB-1:0] low;
   logic          fresh;
   logic          last;
   logic [AW-1:0] addr_f;

   burst_beat_ctrl #(.AW(AW), .LB(LB)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ld_i),
      .adv     (adv_i),
      .sleep   (sleep_i),
      .addr_in (addr_i),
      .base    (base),
      .beat    (beat),
      .fresh   (fresh)
   );

   burst_order_map #(.LB(LB)) u_map (
      .start (base[LB-1:0]),
      .beat  (beat),
      .order (order_e'(order_i)),
      .low   (low),
      .last  (last)
   );

   assign addr_f = {base[AW-1:LB], low};

   burst_out_stage #(.AW(AW)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .timing    (timing_e'(pipe_i)),
      .sleep     (sleep_i),
      .addr_f    (addr_f),
      .valid_f   (fresh),
      .done_f    (fresh && last),
      .addr_o    (addr_o),
      .valid_o   (valid_o),
      .done_o    (done_o),
      .standby_o (standby_o)
   );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int AW = 16,
   parameter int LB = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ld_i,
   input logic          adv_i,
   input logic [AW-1:0] addr_i,
   input logic          order_i,
   input logic          pipe_i,
   input logic          sleep_i,
   input logic [AW-1:0] addr_o,
   input logic          valid_o,
   input logic          done_o,
   input logic          standby_o
);
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (!rst_n)           age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   p_standby_mutes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      standby_o |-> !valid_o);
   p_sleep_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> standby_o);
   p_sleep_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_i |=> !standby_o);
   p_done_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> valid_o);
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_upper_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_i && !ld_i) |=> $stable(addr_o[AW-1:LB]));
   p_load_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_i && ld_i && !sleep_i) |=> (valid_o && addr_o == $past(addr_i)));
   p_linear_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_i && !order_i && adv_i && !ld_i && !sleep_i && valid_o)
      |=> (addr_o[LB-1:0] == LB'($past(addr_o[LB-1:0]) + LB'(1))));
   p_pipe_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && pipe_i && $past(ld_i && !sleep_i, 2) && !standby_o)
      |-> (valid_o && addr_o == $past(addr_i, 2)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .LB(LB)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_i      (ld_i),
   .adv_i     (adv_i),
   .addr_i    (addr_i),
   .order_i   (order_i),
   .pipe_i    (pipe_i),
   .sleep_i   (sleep_i),
   .addr_o    (addr_o),
   .valid_o   (valid_o),
   .done_o    (done_o),
   .standby_o (standby_o)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ld_i, adv_i, order_i, pipe_i, sleep_i;
   logic [AW-1:0] addr_i;
   logic [AW-1:0] addr_o;
   logic          valid_o, done_o, standby_o;

   int nchk = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   burst_addr_seq #(.AW(AW), .LB(2)) dut (
      .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .adv_i(adv_i), .addr_i(addr_i),
      .order_i(order_i), .pipe_i(pipe_i), .sleep_i(sleep_i),
      .addr_o(addr_o), .valid_o(valid_o), .done_o(done_o), .standby_o(standby_o)
   );

   // {order, pipe, start[1:0], beat1..beat4 low bits}
   localparam logic [11:0] VEC [0:6] = '{
      {1'b0, 1'b0, 2'b01, 8'b01_10_11_00},
      {1'b0, 1'b0, 2'b11, 8'b11_00_01_10},
      {1'b1, 1'b0, 2'b01, 8'b01_00_11_10},
      {1'b1, 1'b0, 2'b11, 8'b11_10_01_00},
      {1'b0, 1'b1, 2'b10, 8'b10_11_00_01},
      {1'b1, 1'b1, 2'b10, 8'b10_11_00_01},
      {1'b1, 1'b1, 2'b01, 8'b01_00_11_10}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic ld, input logic adv, input logic slp, input logic [AW-1:0] a);
      @(negedge clk);
      ld_i = ld; adv_i = adv; sleep_i = slp; addr_i = a;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      cyc(1'b0, 1'b0, 1'b0, '0);
   endtask

   task automatic beat_chk(input logic [11:0] v, input logic [AW-1:0] a, input int k);
      logic [1:0] lo;
      string tag;
      lo  = (k == 4) ? v[9:8] : v[7-2*k -: 2];
      tag = v[11] ? "R3" : "R2";
      if (k == 4) tag = "R4";
      if (v[10]) tag = {tag, "/R7"};
      chk({tag, " valid"}, {31'd0, valid_o}, 32'd1);
      chk({tag, "/R5 addr"}, {16'd0, addr_o}, {16'd0, a[AW-1:2], lo});
      chk("R9 done", {31'd0, done_o}, {31'd0, (k == 3)});
   endtask

   initial begin
      rst_n = 1'b0; ld_i = 0; adv_i = 0; order_i = 0; pipe_i = 0; sleep_i = 0; addr_i = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R11 addr", {16'd0, addr_o}, 32'd0);
      chk("R11 valid", {31'd0, valid_o}, 32'd0);
      chk("R11 done", {31'd0, done_o}, 32'd0);
      chk("R11 standby", {31'd0, standby_o}, 32'd0);
      @(negedge clk) rst_n = 1'b1;

      // R10: advance with nothing loaded
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk("R10 valid", {31'd0, valid_o}, 32'd0);
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk("R10 valid again", {31'd0, valid_o}, 32'd0);

      // table walk
      for (int i = 0; i < 7; i++) begin
         logic [11:0]   v;
         logic [AW-1:0] a;
         v = VEC[i];
         a = 16'h3A50 + AW'(i << 4) + AW'(v[9:8]);
         @(negedge clk);
         order_i = v[11]; pipe_i = v[10];
         idle(); idle();
         for (int k = 0; k < 5; k++) begin
            cyc(k == 0, k != 0, 1'b0, (k == 0) ? a : 16'hFFFF);
            if (!v[10]) beat_chk(v, a, k);
            else if (k > 0) beat_chk(v, a, k - 1);
            else chk("R7 not yet valid", {31'd0, valid_o}, 32'd0);
         end
         idle();
         if (v[10]) begin
            beat_chk(v, a, 4);
            idle();
         end
         chk("R1 valid drops", {31'd0, valid_o}, 32'd0);
      end

      // R6: load beats advance in the same cycle
      @(negedge clk); order_i = 0; pipe_i = 0;
      idle(); idle();
      cyc(1'b1, 1'b0, 1'b0, 16'h1230);
      chk("R1 addr", {16'd0, addr_o}, 32'h1230);
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk("R2 addr", {16'd0, addr_o}, 32'h1231);
      cyc(1'b1, 1'b1, 1'b0, 16'h4562);
      chk("R6 restart addr", {16'd0, addr_o}, 32'h4562);
      chk("R6 restart valid", {31'd0, valid_o}, 32'd1);
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk("R6 second beat", {16'd0, addr_o}, 32'h4563);
      chk("R6 no done", {31'd0, done_o}, 32'd0);

      // R8: standby holds state and ignores commands
      idle();
      cyc(1'b1, 1'b0, 1'b0, 16'h00A4);
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk("R8 pre addr", {16'd0, addr_o}, 32'h00A5);
      cyc(1'b1, 1'b1, 1'b1, 16'h7777);
      chk("R8 standby", {31'd0, standby_o}, 32'd1);
      chk("R8 valid low", {31'd0, valid_o}, 32'd0);
      chk("R8 addr held", {16'd0, addr_o}, 32'h00A5);
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk("R8 standby off", {31'd0, standby_o}, 32'd0);
      chk("R8 resume addr", {16'd0, addr_o}, 32'h00A6);
      chk("R8 resume valid", {31'd0, valid_o}, 32'd1);
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk("R9 done on fourth", {31'd0, done_o}, 32'd1);
      chk("R9 fourth addr", {16'd0, addr_o}, 32'h00A7);
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk("R9 done single", {31'd0, done_o}, 32'd0);
      chk("R4 wrap addr", {16'd0, addr_o}, 32'h00A4);

      // R7: pipelined latency in isolation
      idle();
      @(negedge clk); pipe_i = 1;
      idle(); idle();
      cyc(1'b1, 1'b0, 1'b0, 16'h2221);
      chk("R7 first edge", {31'd0, valid_o}, 32'd0);
      idle();
      chk("R7 second edge valid", {31'd0, valid_o}, 32'd1);
      chk("R7 second edge addr", {16'd0, addr_o}, 32'h2221);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule